// File: doc/BRIEF.md
# Two-wide register renamer with branch checkpoints

The block translates the architectural register numbers of up to two instructions per cycle into physical register tags. A speculative map table gives the current tag of every architectural register. A ring of free tags hands out new destinations in first-in first-out order. A committed map table holds the architecturally retired state. When rename and commit run in step, the block keeps the speculative state precise enough to be rewound to any unresolved branch or to the last retired instruction.

Each renamed branch takes a snapshot of the speculative map and of the free-ring read position. A mispredict rewinds both to that snapshot in one cycle and drops all younger snapshots. An exception copies the committed map back into the speculative map and returns every uncommitted allocation to the free ring. The commit stage only names the retiring instruction's destination register. The block derives the tag to release from its own committed map. Outputs are combinational in the same cycle as the request. State changes at the following clock edge.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register xN maps to physical tag N for N in 0..31, and tags 32..63 are free in ascending order. The first allocations return 32, 33, and so on, and the checkpoint id output is 0.
- R2: Destination tags are taken from the free ring in FIFO order. Slot 0 allocates before slot 1, and the two tags of one pair differ.
- R3: A destination field of 0 means no destination. It allocates nothing and reports tag 0. A source field of 0 always yields tag 0.
- R4: Each source tag and each old-destination tag is read from the speculative map as left by all older accepted renames.
- R5: When slot 1 reads, or overwrites, the register that slot 0 writes in the same pair, slot 1 gets slot 0's new tag as its source or old-destination tag.
- R6: If the free ring holds fewer tags than the pair needs, `rn_stall` is high and no part of the pair takes effect.
- R7: Committing an instruction with a non-zero destination returns that register's previously committed tag to the tail of the free ring.
- R8: A mispredict on checkpoint k restores the map as it stood right after that branch renamed. Tags allocated by younger instructions go back to the head of the free ring in their original order.
- R9: At most NUM_CKPT snapshots are live. A pair holding a branch stalls while all are in use, and committing a branch releases the oldest one.
- R10: An exception copies the committed map into the speculative map, returns every uncommitted tag to the free ring, and drops all snapshots.
- R11: While a mispredict or an exception is signalled, any rename request stalls and is ignored.
- R12: A renamed branch receives checkpoint id `rn_ckpt`. Ids are handed out in increasing order modulo NUM_CKPT, and after a mispredict on k the next id is k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rn_valid | input | 2 | Rename request valid per slot (slot 0 older) |
| rn_rs1 | input | 2x5 | First source register per slot |
| rn_rs2 | input | 2x5 | Second source register per slot |
| rn_rd | input | 2x5 | Destination register per slot, 0 = none |
| rn_branch | input | 2 | Slot holds a branch needing a snapshot (at most one per pair) |
| rn_stall | output | 1 | Pair not accepted this cycle |
| rn_ps1 | output | 2x6 | Physical tag of first source |
| rn_ps2 | output | 2x6 | Physical tag of second source |
| rn_pd | output | 2x6 | Newly allocated destination tag |
| rn_pold | output | 2x6 | Previous tag of the destination register |
| rn_ckpt | output | 2 | Checkpoint id given to the pair's branch |
| cm_valid | input | 2 | Commit valid per slot, in program order |
| cm_rd | input | 2x5 | Destination register of the committing instruction |
| cm_branch | input | 2 | Committing instruction is a branch |
| br_mispredict | input | 1 | Restore from a branch snapshot |
| br_ckpt | input | 2 | Checkpoint id of the mispredicted branch |
| exc_flush | input | 1 | Restore from the committed map |

## Verification
The assertions assume that rename and commit run in step. Every committing instruction was renamed earlier and was not flushed. Commits arrive in program order. A mispredict always names a checkpoint that is still live, and a pair carries at most one branch. The bench keeps within these limits by driving commits and mispredicts only from the contents of its own in-flight list and live-snapshot list. It never commits in a flush cycle and never marks both slots as branches. Random pairs draw register numbers from a narrow range so that same-pair hazards and x0 fields occur often.

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  parameter int NUM_CKPT = 4,
  parameter int AW = $clog2(NUM_ARCH),
  parameter int PW = $clog2(NUM_PHYS),
  parameter int CW = $clog2(NUM_CKPT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           rn_valid,
  input  logic [1:0][AW-1:0]   rn_rs1,
  input  logic [1:0][AW-1:0]   rn_rs2,
  input  logic [1:0][AW-1:0]   rn_rd,
  input  logic [1:0]           rn_branch,
  output logic                 rn_stall,
  output logic [1:0][PW-1:0]   rn_ps1,
  output logic [1:0][PW-1:0]   rn_ps2,
  output logic [1:0][PW-1:0]   rn_pd,
  output logic [1:0][PW-1:0]   rn_pold,
  output logic [CW-1:0]        rn_ckpt,
  input  logic [1:0]           cm_valid,
  input  logic [1:0][AW-1:0]   cm_rd,
  input  logic [1:0]           cm_branch,
  input  logic                 br_mispredict,
  input  logic [CW-1:0]        br_ckpt,
  input  logic                 exc_flush
);

  localparam int FD  = NUM_PHYS - NUM_ARCH;
  localparam int FW  = $clog2(FD);
  localparam int FPW = FW + 1;
  localparam int CPW = CW + 1;

  logic [PW-1:0]  spec_map [NUM_ARCH];
  logic [PW-1:0]  cmt_map  [NUM_ARCH];
  logic [PW-1:0]  ring     [FD];
  logic [FPW-1:0] alloc_ptr, retire_ptr;
  logic [PW-1:0]  snap_map [NUM_CKPT][NUM_ARCH];
  logic [FPW-1:0] snap_ptr [NUM_CKPT];
  logic [CPW-1:0] ck_head, ck_tail;

  // rename side
  logic [1:0]     dv;
  logic [FPW-1:0] need, nfree, ap1;
  logic           br_any, ck_full, flush, fire;
  logic [PW-1:0]  pd0, pd1;

  assign dv[0]   = rn_valid[0] && rn_rd[0] != '0;
  assign dv[1]   = rn_valid[1] && rn_rd[1] != '0;
  assign need    = FPW'(dv[0]) + FPW'(dv[1]);
  assign nfree   = FPW'(FD) - (alloc_ptr - retire_ptr);
  assign br_any  = |(rn_valid & rn_branch);
  assign ck_full = (ck_tail - ck_head) == CPW'(NUM_CKPT);
  assign flush   = br_mispredict | exc_flush;
  assign rn_stall = (|rn_valid) & (flush | (nfree < need) | (br_any & ck_full));
  assign fire    = (|rn_valid) & ~rn_stall;

  assign ap1 = alloc_ptr + FPW'(dv[0]);
  assign pd0 = dv[0] ? ring[alloc_ptr[FW-1:0]] : '0;
  assign pd1 = dv[1] ? ring[ap1[FW-1:0]] : '0;

  assign rn_pd[0]   = pd0;
  assign rn_pd[1]   = pd1;
  assign rn_ps1[0]  = spec_map[rn_rs1[0]];
  assign rn_ps2[0]  = spec_map[rn_rs2[0]];
  assign rn_ps1[1]  = (dv[0] && rn_rs1[1] == rn_rd[0]) ? pd0 : spec_map[rn_rs1[1]];
  assign rn_ps2[1]  = (dv[0] && rn_rs2[1] == rn_rd[0]) ? pd0 : spec_map[rn_rs2[1]];
  assign rn_pold[0] = dv[0] ? spec_map[rn_rd[0]] : '0;
  assign rn_pold[1] = !dv[1] ? '0 :
                      (dv[0] && rn_rd[1] == rn_rd[0]) ? pd0 : spec_map[rn_rd[1]];
  assign rn_ckpt    = ck_tail[CW-1:0];

  logic [PW-1:0] map_a [NUM_ARCH];
  logic [PW-1:0] map_b [NUM_ARCH];
  always_comb begin
    map_a = spec_map;
    if (dv[0]) map_a[rn_rd[0]] = pd0;
    map_b = map_a;
    if (dv[1]) map_b[rn_rd[1]] = pd1;
  end

  // commit side
  logic [1:0]     cv;
  logic [FPW-1:0] ci1, retire_nx;
  logic [PW-1:0]  cnew0, cnew1, cold0, cold1;
  logic [CPW-1:0] ck_head_nx, mp_tail;
  logic [CW-1:0]  mp_off;
  logic [PW-1:0]  cmt_nx [NUM_ARCH];

  assign cv[0]     = cm_valid[0] && cm_rd[0] != '0;
  assign cv[1]     = cm_valid[1] && cm_rd[1] != '0;
  assign ci1       = retire_ptr + FPW'(cv[0]);
  assign retire_nx = ci1 + FPW'(cv[1]);
  assign cnew0     = ring[retire_ptr[FW-1:0]];
  assign cnew1     = ring[ci1[FW-1:0]];
  assign cold0     = cmt_map[cm_rd[0]];
  assign cold1     = (cv[0] && cm_rd[1] == cm_rd[0]) ? cnew0 : cmt_map[cm_rd[1]];
  assign ck_head_nx = ck_head + CPW'(cm_valid[0] & cm_branch[0])
                              + CPW'(cm_valid[1] & cm_branch[1]);
  assign mp_off    = br_ckpt - ck_head[CW-1:0];
  assign mp_tail   = ck_head + CPW'(mp_off) + CPW'(1);

  always_comb begin
    cmt_nx = cmt_map;
    if (cv[0]) cmt_nx[cm_rd[0]] = cnew0;
    if (cv[1]) cmt_nx[cm_rd[1]] = cnew1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_ARCH; r++) begin
        spec_map[r] <= PW'(r);
        cmt_map[r]  <= PW'(r);
      end
      for (int i = 0; i < FD; i++) ring[i] <= PW'(NUM_ARCH + i);
      alloc_ptr  <= '0;
      retire_ptr <= '0;
      ck_head    <= '0;
      ck_tail    <= '0;
    end else begin
      cmt_map    <= cmt_nx;
      retire_ptr <= retire_nx;
      ck_head    <= ck_head_nx;
      if (cv[0]) ring[retire_ptr[FW-1:0]] <= cold0;
      if (cv[1]) ring[ci1[FW-1:0]]        <= cold1;
      if (exc_flush) begin
        spec_map  <= cmt_nx;
        alloc_ptr <= retire_nx;
        ck_tail   <= ck_head_nx;
      end else if (br_mispredict) begin
        for (int r = 0; r < NUM_ARCH; r++) spec_map[r] <= snap_map[br_ckpt][r];
        alloc_ptr <= snap_ptr[br_ckpt];
        ck_tail   <= mp_tail;
      end else if (fire) begin
        spec_map  <= map_b;
        alloc_ptr <= alloc_ptr + need;
        if (br_any) ck_tail <= ck_tail + CPW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fire && br_any) begin
      for (int r = 0; r < NUM_ARCH; r++)
        snap_map[ck_tail[CW-1:0]][r] <= rn_branch[0] && rn_valid[0] ? map_a[r] : map_b[r];
      snap_ptr[ck_tail[CW-1:0]] <= (rn_branch[0] && rn_valid[0]) ? ap1 : alloc_ptr + need;
    end
  end

endmodule

// File: rtl/reg_rename_chk.sv
module reg_rename_chk #(
  parameter int AW = 5,
  parameter int PW = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         rn_valid,
  input logic [1:0][AW-1:0] rn_rs1,
  input logic [1:0][AW-1:0] rn_rd,
  input logic               rn_stall,
  input logic [1:0][PW-1:0] rn_ps1,
  input logic [1:0][PW-1:0] rn_pd,
  input logic [1:0][PW-1:0] rn_pold,
  input logic               br_mispredict,
  input logic               exc_flush
);

  for (genvar s = 0; s < 2; s++) begin : g_slot
    assert_x0_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rn_valid[s] && rn_rs1[s] == '0) |-> rn_ps1[s] == '0)
      else $error("x0 source not mapped to tag 0");
    assert_new_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rn_valid[s] && rn_rd[s] != '0 && !rn_stall) |-> rn_pd[s] != '0)
      else $error("allocated tag 0");
  end

  assert_pair_distinct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&rn_valid && rn_rd[0] != '0 && rn_rd[1] != '0 && !rn_stall) |-> rn_pd[0] != rn_pd[1])
    else $error("pair got the same tag");

  assert_src_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (&rn_valid && rn_rd[0] != '0 && rn_rs1[1] == rn_rd[0] && !rn_stall) |-> rn_ps1[1] == rn_pd[0])
    else $error("slot 1 missed slot 0 result");

  assert_old_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (&rn_valid && rn_rd[0] != '0 && rn_rd[1] == rn_rd[0] && !rn_stall) |-> rn_pold[1] == rn_pd[0])
    else $error("slot 1 old tag wrong");

  assert_flush_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((br_mispredict || exc_flush) && |rn_valid) |-> rn_stall)
    else $error("rename accepted during flush");

endmodule

bind reg_rename reg_rename_chk #(.AW(AW), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_rs1(rn_rs1), .rn_rd(rn_rd),
  .rn_stall(rn_stall), .rn_ps1(rn_ps1), .rn_pd(rn_pd), .rn_pold(rn_pold),
  .br_mispredict(br_mispredict), .exc_flush(exc_flush)
);

// File: tb/reg_rename_tb_top.sv
module reg_rename_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 32;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]      rn_valid = '0, rn_branch = '0, cm_valid = '0, cm_branch = '0;
  logic [1:0][4:0] rn_rs1 = '0, rn_rs2 = '0, rn_rd = '0, cm_rd = '0;
  logic            br_mispredict = 1'b0, exc_flush = 1'b0, rn_stall;
  logic [1:0]      br_ckpt = '0, rn_ckpt;
  logic [1:0][5:0] rn_ps1, rn_ps2, rn_pd, rn_pold;

  reg_rename dut_i (
    .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_rs1(rn_rs1), .rn_rs2(rn_rs2),
    .rn_rd(rn_rd), .rn_branch(rn_branch), .rn_stall(rn_stall), .rn_ps1(rn_ps1),
    .rn_ps2(rn_ps2), .rn_pd(rn_pd), .rn_pold(rn_pold), .rn_ckpt(rn_ckpt),
    .cm_valid(cm_valid), .cm_rd(cm_rd), .cm_branch(cm_branch),
    .br_mispredict(br_mispredict), .br_ckpt(br_ckpt), .exc_flush(exc_flush)
  );

  int n_tot = 0, n_bad = 0;
  bit done = 0;
  string src_req = "R4", pd_req = "R2";

  int m_map[NA], m_cmt[NA];
  int snap[NC][NA];
  int fq[$];
  int rob_rd[$], rob_pd[$], rob_ck[$];
  bit rob_br[$];
  int ckq[$];
  int ck_next = 0, ck_head_id = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_tot++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rewind(input int keep);
    while (rob_rd.size() > keep) begin
      int p;
      p = rob_pd.pop_back();
      void'(rob_rd.pop_back());
      void'(rob_ck.pop_back());
      void'(rob_br.pop_back());
      if (p != 0) fq.push_front(p);
    end
  endtask

  task automatic cycle(input bit [1:0] v, input int rd0, input int rd1,
                       input int a0, input int b0, input int a1, input int b1,
                       input bit [1:0] br, input int ncm, input bit mp,
                       input int mpk, input bit ex);
    int rdv[2], av[2], bv[2], pdv[2];
    int t[NA];
    int need, fidx;
    bit bra, exp_stall;
    string rq;
    rdv[0] = rd0; rdv[1] = rd1; av[0] = a0; av[1] = a1; bv[0] = b0; bv[1] = b1;
    @(negedge clk);
    rn_valid = v; rn_branch = br;
    for (int s = 0; s < 2; s++) begin
      rn_rd[s] = rdv[s][4:0]; rn_rs1[s] = av[s][4:0]; rn_rs2[s] = bv[s][4:0];
    end
    cm_valid = '0; cm_rd = '0; cm_branch = '0;
    for (int k = 0; k < ncm; k++) begin
      cm_valid[k] = 1'b1; cm_rd[k] = rob_rd[k][4:0]; cm_branch[k] = rob_br[k];
    end
    br_mispredict = mp; br_ckpt = mpk[1:0]; exc_flush = ex;
    #1;
    need = ((v[0] && rd0 != 0) ? 1 : 0) + ((v[1] && rd1 != 0) ? 1 : 0);
    bra = (v[0] && br[0]) || (v[1] && br[1]);
    exp_stall = (v != 0) && (mp || ex || fq.size() < need || (bra && ckq.size() == NC));
    rq = (mp || ex) ? "R11" : (bra && ckq.size() == NC) ? "R9" : "R6";
    chk(rq, int'(rn_stall), int'(exp_stall));
    if (!exp_stall && v != 0) begin
      t = m_map;
      fidx = 0;
      for (int s = 0; s < 2; s++) begin
        if (v[s]) begin
          bit byp;
          byp = (s == 1) && v[0] && rdv[0] != 0;
          rq = (av[s] == 0) ? "R3" : (byp && av[s] == rdv[0]) ? "R5" : src_req;
          chk(rq, int'(rn_ps1[s]), t[av[s]]);
          rq = (bv[s] == 0) ? "R3" : (byp && bv[s] == rdv[0]) ? "R5" : src_req;
          chk(rq, int'(rn_ps2[s]), t[bv[s]]);
          rq = (byp && rdv[s] == rdv[0]) ? "R5" : "R4";
          chk(rq, int'(rn_pold[s]), rdv[s] != 0 ? t[rdv[s]] : 0);
          pdv[s] = rdv[s] != 0 ? fq[fidx] : 0;
          chk(rdv[s] == 0 ? "R3" : pd_req, int'(rn_pd[s]), pdv[s]);
          if (rdv[s] != 0) begin
            t[rdv[s]] = pdv[s];
            fidx++;
          end
          rob_rd.push_back(rdv[s]); rob_pd.push_back(pdv[s]);
          rob_br.push_back(br[s]); rob_ck.push_back(br[s] ? ck_next : 0);
          if (br[s]) begin
            chk("R12", int'(rn_ckpt), ck_next);
            for (int r = 0; r < NA; r++) snap[ck_next][r] = t[r];
            ckq.push_back(ck_next);
            ck_next = (ck_next + 1) % NC;
          end
        end
      end
      m_map = t;
      for (int k = 0; k < fidx; k++) void'(fq.pop_front());
    end
    for (int k = 0; k < ncm; k++) begin
      int crd, cpd;
      bit cbr;
      crd = rob_rd.pop_front(); cpd = rob_pd.pop_front();
      cbr = rob_br.pop_front(); void'(rob_ck.pop_front());
      if (crd != 0) begin
        fq.push_back(m_cmt[crd]);
        m_cmt[crd] = cpd;
      end
      if (cbr) begin
        void'(ckq.pop_front());
        ck_head_id = (ck_head_id + 1) % NC;
      end
    end
    if (ex) begin
      rewind(0);
      m_map = m_cmt;
      ckq.delete();
      ck_next = ck_head_id;
    end else if (mp) begin
      int j;
      j = -1;
      for (int i = 0; i < rob_rd.size(); i++)
        if (rob_br[i] && rob_ck[i] == mpk) j = i;
      rewind(j + 1);
      for (int r = 0; r < NA; r++) m_map[r] = snap[mpk][r];
      while (ckq.size() > 0 && ckq[ckq.size()-1] != mpk) void'(ckq.pop_back());
      ck_next = (mpk + 1) % NC;
    end
  endtask

  task automatic idle();
    cycle(2'b00, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tot++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    int kk;
    void'($urandom(32'd4242));
    for (int r = 0; r < NA; r++) begin m_map[r] = r; m_cmt[r] = r; end
    for (int i = NA; i < 64; i++) fq.push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", int'(rn_stall), 0);
    chk("R1", int'(rn_ckpt), 0);

    // R1 reset mapping and first allocations
    src_req = "R1"; pd_req = "R1";
    cycle(2'b11, 1, 2, 5, 6, 7, 8, 2'b00, 0, 0, 0, 0);
    src_req = "R4"; pd_req = "R2";

    // R6 exhaust the free ring
    for (int k = 0; k < 14; k++) cycle(2'b11, (k % 31) + 1, ((k + 7) % 31) + 1, 1, 2, 3, 4, 2'b00, 0, 0, 0, 0);
    cycle(2'b01, 9, 0, 9, 1, 0, 0, 2'b00, 0, 0, 0, 0);
    cycle(2'b11, 3, 4, 1, 1, 1, 1, 2'b00, 0, 0, 0, 0);
    cycle(2'b01, 5, 0, 1, 1, 0, 0, 2'b00, 0, 0, 0, 0);
    cycle(2'b01, 6, 0, 1, 1, 0, 0, 2'b00, 0, 0, 0, 0);

    // R10 exception restores committed state
    cycle(2'b00, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 1);
    src_req = "R10"; pd_req = "R10";
    cycle(2'b11, 9, 10, 1, 2, 3, 4, 2'b00, 0, 0, 0, 0);
    src_req = "R4";

    // R7 commit releases old committed tags to the tail
    cycle(2'b00, 0, 0, 0, 0, 0, 0, 2'b00, 2, 0, 0, 0);
    pd_req = "R7";
    for (int k = 0; k < 16; k++) cycle(2'b11, 11, 12, 9, 10, 11, 12, 2'b00, 0, 0, 0, 0);
    pd_req = "R2";
    cycle(2'b00, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 1);

    // R9 snapshot limit
    for (int k = 0; k < 5; k++) cycle(2'b01, 0, 0, 1, 2, 0, 0, 2'b01, 0, 0, 0, 0);
    cycle(2'b00, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 1);

    // R8 mispredict restore
    kk = ck_next;
    cycle(2'b11, 4, 5, 1, 2, 4, 3, 2'b01, 0, 0, 0, 0);
    cycle(2'b11, 4, 6, 5, 4, 6, 6, 2'b00, 0, 0, 0, 0);
    cycle(2'b00, 0, 0, 0, 0, 0, 0, 2'b00, 0, 1, kk, 0);
    src_req = "R8"; pd_req = "R8";
    cycle(2'b11, 7, 8, 4, 5, 6, 4, 2'b00, 0, 0, 0, 0);
    src_req = "R4"; pd_req = "R2";

    // R11 rename ignored during a flush
    cycle(2'b11, 1, 2, 4, 5, 6, 7, 2'b00, 0, 1, kk, 0);
    src_req = "R11";
    cycle(2'b11, 9, 10, 7, 8, 1, 2, 2'b00, 0, 0, 0, 0);
    src_req = "R4";
    cycle(2'b00, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 1);

    // constrained random traffic
    for (int it = 0; it < 4000; it++) begin
      int r, ncm, mx;
      bit [1:0] v, br;
      r = $urandom_range(0, 99);
      if (r < 4 && ckq.size() > 0) begin
        cycle(2'b00, 0, 0, 0, 0, 0, 0, 2'b00, 0, 1,
              ckq[$urandom_range(0, ckq.size() - 1)], 0);
      end else if (r < 6) begin
        cycle(2'b00, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 1);
      end else begin
        v = 2'($urandom_range(0, 3));
        br = 2'b00;
        if ($urandom_range(0, 4) == 0) br[$urandom_range(0, 1)] = 1'b1;
        mx = rob_rd.size() < 2 ? rob_rd.size() : 2;
        ncm = $urandom_range(0, 3);
        if (ncm > mx) ncm = mx;
        cycle(v, $urandom_range(0, 9), $urandom_range(0, 9),
              $urandom_range(0, 9), $urandom_range(0, 31),
              $urandom_range(0, 9), $urandom_range(0, 31),
              br & v, ncm, 0, 0, 0);
      end
    end
    idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule